// File: doc/BRIEF.md
# Full-Duplex SPI Master with In-Place Data Buffer

This block is a register-programmed SPI master. Software fills a data buffer of 64 bytes through a word-wide register port. It programs the clock mode, the bit and byte ordering, the chip-select timing and the transmit and receive lengths, then writes a start command. The engine shifts the buffer out on MOSI. When full duplex is enabled, it samples MISO during the same clock periods. Each received bit is written back into the same buffer location scheme, so the transmitted data is replaced in place.

The serial clock is paced by an external `sclk_tick` strobe. Each tick advances the bus by one half period, or by one half period of chip-select setup or hold. The busy flag in the command register clears itself when the last edge (or the hold phase) is done. Software polls that flag and then reads the received words from the buffer.

Top module: `spim_top`

## Requirements
- R1: After reset the command register reads 0 (not busy), the configuration and length registers read 0, `spi_cs_n` is 1, `spi_sclk` is 0 and `spi_mosi` is 0.
- R2: Register map by word address. Addresses 0 to 15 are buffer words. Address 16 is the command register: bit 0 is start on write and busy on read. Address 17 is the configuration register. Address 18 is the length register. While idle, every buffer word, the configuration register and the length register read back the value last written.
- R3: Writing 1 to command bit 0 while idle starts a transfer. From the next cycle busy reads 1 and `spi_cs_n` is 0. When the transfer completes, busy returns to 0 in the same cycle that `spi_cs_n` returns to 1.
- R4: Length register: bits [8:0] hold the transmit bit count minus one, and bits [24:16] hold the receive bit count minus one. The data phase lasts N bits, with two `spi_sclk` edges per bit. N is the transmit count when duplex is off, and the larger of the two counts when duplex is on.
- R5: Configuration bit 1 sets the idle level of `spi_sclk` (polarity). Configuration bit 0 sets the phase. With the phase bit clear, data is driven before the leading edge and sampled on it. With the phase bit set, data is driven on the leading edge and sampled on the trailing edge. `spi_sclk` changes only on a tick while `spi_cs_n` is low.
- R6: Configuration bit 2 (transmit) and bit 3 (receive) select the bit order inside each byte. Clear means most significant bit first; set means least significant bit first.
- R7: Buffer byte k of the stream sits in word k/4. With configuration bit 4 clear, lane k%4 of that word holds bits [8*lane+7:8*lane]. With bit 4 set, the lanes are reversed (3 - k%4). The same mapping is used for transmit and receive.
- R8: With configuration bit 5 (duplex) set, the MISO bit for stream position n replaces the buffer bit at the position that R6/R7 give for n under the receive bit order. With duplex clear, the buffer is left unchanged.
- R9: Stream bits past the transmit count are driven as 0 on MOSI. Bits past the receive count are not written into the buffer.
- R10: Configuration bit 6 adds two ticks of chip-select setup before the first `spi_sclk` edge. Configuration bit 7 adds two ticks of hold after the last edge before `spi_cs_n` rises.
- R11: While busy, register writes are ignored: a second start, buffer words, configuration and length. The running transfer completes unchanged, and no second transfer follows it.
- R12: Whenever `spi_cs_n` is 1, `spi_sclk` equals the programmed idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_tick | input | 1 | Half-period strobe from the clock divider |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest situation to reach is a receive bit landing in a buffer byte that still has transmit bits waiting to go out. This happens when the transmit and receive bit orders differ, or when the byte lanes are swapped. The stimulus reaches it with table rows that mix opposite bit orders, lane swapping, unequal transmit and receive counts and all four clock modes. A bus-level slave model captures MOSI and returns a position-dependent MISO pattern. A second corner, writes issued in the middle of a transfer, is reached by poking the command, buffer and configuration registers while busy, then checking that the stream, the buffer and the configuration come out untouched.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_HOLD  = 2'd3
    } spim_state_e;

    // first member is the most significant bit: cpha lands on bit 0
    typedef struct packed {
        logic cs_hold;
        logic cs_setup;
        logic duplex;
        logic lane_swap;
        logic rx_lsb;
        logic tx_lsb;
        logic cpol;
        logic cpha;
    } spim_cfg_t;

endpackage

// File: rtl/spim_buffer.sv
module spim_buffer #(
    parameter int BUF_WORDS = 16,
    localparam int BUF_BITS = BUF_WORDS * 32,
    localparam int BIT_W    = $clog2(BUF_BITS),
    localparam int BYTE_W   = BIT_W - 3,
    localparam int WORD_W   = BIT_W - 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [BYTE_W-1:0] byte_addr,
    output logic [7:0]        byte_data,
    input  logic              rx_we,
    input  logic [BIT_W-1:0]  rx_pos,
    input  logic              rx_bit
);

    logic [BUF_BITS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (bus_we) begin
            mem_d[{bus_word, 5'b00000} +: 32] = bus_wdata;
        end
        if (rx_we) begin
            mem_d[rx_pos] = rx_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign bus_rdata = mem_q[{bus_word, 5'b00000} +: 32];
    assign byte_data = mem_q[{byte_addr, 3'b000} +: 8];

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int BUF_WORDS = 16,
    localparam int BIT_W    = $clog2(BUF_WORDS * 32),
    localparam int WORD_W   = $clog2(BUF_WORDS),
    localparam int ADDR_W   = WORD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    output logic              start,
    output logic              buf_we,
    output logic [WORD_W-1:0] buf_word,
    input  logic [31:0]       buf_rdata,
    output spim_cfg_t         cfg,
    output logic [BIT_W-1:0]  tx_last,
    output logic [BIT_W-1:0]  rx_last
);

    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(BUF_WORDS);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(BUF_WORDS + 1);
    localparam logic [ADDR_W-1:0] A_LEN = ADDR_W'(BUF_WORDS + 2);

    typedef struct packed {
        spim_cfg_t        cfg;
        logic [BIT_W-1:0] tx_last;
        logic [BIT_W-1:0] rx_last;
    } ctrl_s;

    ctrl_s r_d, r_q;
    logic  wr_ok;
    logic  is_buf;

    assign wr_ok    = reg_we && !busy;
    assign is_buf   = !reg_addr[ADDR_W-1];
    assign buf_word = reg_addr[WORD_W-1:0];
    assign buf_we   = wr_ok && is_buf;
    assign start    = wr_ok && (reg_addr == A_CMD) && reg_wdata[0];

    always_comb begin
        r_d = r_q;
        if (wr_ok && reg_addr == A_CFG) begin
            r_d.cfg = spim_cfg_t'(reg_wdata[7:0]);
        end
        if (wr_ok && reg_addr == A_LEN) begin
            r_d.tx_last = reg_wdata[BIT_W-1:0];
            r_d.rx_last = reg_wdata[16 +: BIT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (is_buf) begin
            reg_rdata = buf_rdata;
        end else if (reg_addr == A_CMD) begin
            reg_rdata[0] = busy;
        end else if (reg_addr == A_CFG) begin
            reg_rdata[7:0] = r_q.cfg;
        end else if (reg_addr == A_LEN) begin
            reg_rdata[BIT_W-1:0]   = r_q.tx_last;
            reg_rdata[16 +: BIT_W] = r_q.rx_last;
        end
    end

    assign cfg     = r_q.cfg;
    assign tx_last = r_q.tx_last;
    assign rx_last = r_q.rx_last;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q)); // R11

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int BUF_WORDS = 16,
    localparam int BIT_W    = $clog2(BUF_WORDS * 32),
    localparam int BYTE_W   = BIT_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  spim_cfg_t         cfg,
    input  logic [BIT_W-1:0]  tx_last,
    input  logic [BIT_W-1:0]  rx_last,
    output logic [BYTE_W-1:0] byte_addr,
    input  logic [7:0]        byte_data,
    output logic              rx_we,
    output logic [BIT_W-1:0]  rx_pos,
    output logic              busy,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi
);

    typedef struct packed {
        spim_state_e      st;
        logic             hcnt;
        logic             trail;
        logic [BIT_W-1:0] idx;
        logic             sclk;
        logic             cs_n;
        logic             mosi;
        logic [7:0]       tx_byte;
    } eng_s;

    eng_s n_d, n_q;

    // stream bit -> physical buffer byte, lanes optionally reversed
    function automatic logic [BYTE_W-1:0] phys_byte(input logic [BIT_W-1:0] i,
                                                    input logic swap);
        logic [BYTE_W-1:0] k;
        k = i[BIT_W-1:3];
        return {k[BYTE_W-1:2], swap ? ~k[1:0] : k[1:0]};
    endfunction

    logic [BIT_W-1:0] last_idx;
    logic [BIT_W-1:0] drv_idx;
    logic [7:0]       cur_byte;
    logic             tx_bit;
    logic             sample_ok;

    assign last_idx  = (cfg.duplex && rx_last > tx_last) ? rx_last : tx_last;
    assign drv_idx   = (n_q.st == ST_XFER && n_q.trail && !cfg.cpha)
                       ? n_q.idx + BIT_W'(1) : n_q.idx;
    assign byte_addr = phys_byte(drv_idx, cfg.lane_swap);
    assign cur_byte  = (drv_idx[2:0] == 3'd0) ? byte_data : n_q.tx_byte;
    assign tx_bit    = (drv_idx > tx_last) ? 1'b0
                     : (cfg.tx_lsb ? cur_byte[drv_idx[2:0]] : cur_byte[~drv_idx[2:0]]);
    assign rx_pos    = {phys_byte(n_q.idx, cfg.lane_swap),
                        cfg.rx_lsb ? n_q.idx[2:0] : ~n_q.idx[2:0]};
    assign sample_ok = cfg.duplex && (n_q.idx <= rx_last);

    always_comb begin
        n_d   = n_q;
        rx_we = 1'b0;
        unique case (n_q.st)
            ST_IDLE: begin
                n_d.sclk  = cfg.cpol;
                n_d.cs_n  = 1'b1;
                n_d.trail = 1'b0;
                n_d.hcnt  = 1'b0;
                n_d.idx   = '0;
                if (start) begin
                    n_d.cs_n = 1'b0;
                    n_d.st   = cfg.cs_setup ? ST_SETUP : ST_XFER;
                    if (!cfg.cpha) begin
                        n_d.mosi    = tx_bit;
                        n_d.tx_byte = cur_byte;
                    end
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    n_d.hcnt = !n_q.hcnt;
                    if (n_q.hcnt) begin
                        n_d.st = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (tick) begin
                    n_d.sclk = !n_q.sclk;
                    if (!n_q.trail) begin
                        n_d.trail = 1'b1;
                        if (cfg.cpha) begin
                            n_d.mosi    = tx_bit;
                            n_d.tx_byte = cur_byte;
                        end else begin
                            rx_we = sample_ok;
                        end
                    end else begin
                        n_d.trail = 1'b0;
                        if (cfg.cpha) begin
                            rx_we = sample_ok;
                        end
                        if (n_q.idx == last_idx) begin
                            n_d.idx  = '0;
                            n_d.hcnt = 1'b0;
                            if (cfg.cs_hold) begin
                                n_d.st = ST_HOLD;
                            end else begin
                                n_d.st   = ST_IDLE;
                                n_d.cs_n = 1'b1;
                            end
                        end else begin
                            n_d.idx = n_q.idx + BIT_W'(1);
                            if (!cfg.cpha) begin
                                n_d.mosi    = tx_bit;
                                n_d.tx_byte = cur_byte;
                            end
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    n_d.hcnt = !n_q.hcnt;
                    if (n_q.hcnt) begin
                        n_d.st   = ST_IDLE;
                        n_d.cs_n = 1'b1;
                    end
                end
            end
            default: n_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q      <= '0;
            n_q.st   <= ST_IDLE;
            n_q.cs_n <= 1'b1;
        end else begin
            n_q <= n_d;
        end
    end

    assign busy = (n_q.st != ST_IDLE);
    assign sclk = busy ? n_q.sclk : cfg.cpol;
    assign cs_n = n_q.cs_n;
    assign mosi = n_q.mosi;

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int BUF_WORDS = 16,
    localparam int BIT_W    = $clog2(BUF_WORDS * 32),
    localparam int BYTE_W   = BIT_W - 3,
    localparam int WORD_W   = $clog2(BUF_WORDS),
    localparam int ADDR_W   = WORD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    spim_cfg_t         cfg;
    logic [BIT_W-1:0]  tx_last, rx_last;
    logic              busy, start, buf_we;
    logic [WORD_W-1:0] buf_word;
    logic [31:0]       buf_rdata;
    logic [BYTE_W-1:0] byte_addr;
    logic [7:0]        byte_data;
    logic              rx_we;
    logic [BIT_W-1:0]  rx_pos;

    spim_ctrl #(.BUF_WORDS(BUF_WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .start     (start),
        .buf_we    (buf_we),
        .buf_word  (buf_word),
        .buf_rdata (buf_rdata),
        .cfg       (cfg),
        .tx_last   (tx_last),
        .rx_last   (rx_last)
    );

    spim_buffer #(.BUF_WORDS(BUF_WORDS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (buf_we),
        .bus_word  (buf_word),
        .bus_wdata (reg_wdata),
        .bus_rdata (buf_rdata),
        .byte_addr (byte_addr),
        .byte_data (byte_data),
        .rx_we     (rx_we),
        .rx_pos    (rx_pos),
        .rx_bit    (spi_miso)
    );

    spim_engine #(.BUF_WORDS(BUF_WORDS)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sclk_tick),
        .start     (start),
        .cfg       (cfg),
        .tx_last   (tx_last),
        .rx_last   (rx_last),
        .byte_addr (byte_addr),
        .byte_data (byte_data),
        .rx_we     (rx_we),
        .rx_pos    (rx_pos),
        .busy      (busy),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi)
    );

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_sclk == cfg.cpol)); // R12

    AST_SCLK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !sclk_tick) |=> $stable(spi_sclk)); // R5

    AST_BUSY_DROP_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> spi_cs_n); // R3

    AST_RX_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (!spi_cs_n && cfg.duplex)); // R8

endmodule

// File: tb/spim_top_tb.sv
module spim_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NBITS      = 512;
    localparam logic [4:0] A_CMD = 5'd16;
    localparam logic [4:0] A_CFG = 5'd17;
    localparam logic [4:0] A_LEN = 5'd18;

    // {cfg, tx_last, rx_last, seed}
    localparam logic [71:0] VEC [9] = '{
        {8'h20, 16'd7,   16'd7,   32'hA5C3_1E77},
        {8'h21, 16'd15,  16'd15,  32'h1234_5678},
        {8'h2E, 16'd31,  16'd31,  32'hCAFE_F00D},
        {8'h33, 16'd31,  16'd31,  32'h0F0F_3C3C},
        {8'h38, 16'd63,  16'd63,  32'h9B1D_4E20},
        {8'h01, 16'd23,  16'd40,  32'h5555_AAAA},
        {8'hE3, 16'd11,  16'd39,  32'h7E57_1D0C},
        {8'h3C, 16'd511, 16'd511, 32'hD00D_BEEF},
        {8'h20, 16'd3,   16'd3,   32'h8421_0F1E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int tick_cnt = 0;

    // slave model state
    logic        cur_cpha = 1'b0;
    logic [31:0] cur_seed = '0;
    int          edges = 0;
    int          total_edges = 0;
    int          setup_ticks = 0;
    int          hold_ticks = 0;
    logic        got [NBITS];
    logic        prev_sclk = 1'b0;
    logic        prev_cs = 1'b1;

    spim_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_tick (sclk_tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick_cnt = (tick_cnt + 1) % 3;
            sclk_tick <= (tick_cnt == 0);
        end
    end

    function automatic logic sbit(input int n);
        return cur_seed[(n * 7) % 32] ^ n[3];
    endfunction

    // bit position in the buffer image of stream bit n
    function automatic int bpos(input int n, input bit swap, input bit lsb);
        int k, lane;
        k = n / 8;
        lane = swap ? 3 - (k % 4) : k % 4;
        return (k / 4) * 32 + lane * 8 + (lsb ? n % 8 : 7 - n % 8);
    endfunction

    always @(negedge clk) begin
        if (prev_cs && !spi_cs_n) begin
            edges = 0;
            setup_ticks = 0;
            hold_ticks = 0;
            if (!cur_cpha) spi_miso <= sbit(0);
        end else begin
            if (sclk_tick && !prev_cs) begin
                if (edges == 0) setup_ticks++;
                if (edges == total_edges) hold_ticks++;
            end
            if (!prev_cs && spi_sclk != prev_sclk) begin
                int n;
                bit lead;
                edges++;
                n = (edges - 1) / 2;
                lead = (edges % 2) == 1;
                if (lead && !cur_cpha) got[n] = spi_mosi;
                if (!lead && !cur_cpha && n + 1 < NBITS) spi_miso <= sbit(n + 1);
                if (lead && cur_cpha) spi_miso <= sbit(n);
                if (!lead && cur_cpha) got[n] = spi_mosi;
            end
        end
        prev_sclk = spi_sclk;
        prev_cs = spi_cs_n;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_vec(input logic [71:0] v, input bit poke);
        logic [7:0]       cfg;
        int               txl, rxl, last, errs;
        logic [NBITS-1:0] img, exp_img;
        logic [31:0]      rd;
        cfg = v[71:64];
        txl = int'(v[63:48]);
        rxl = int'(v[47:32]);
        cur_seed = v[31:0];
        cur_cpha = cfg[0];
        for (int w = 0; w < 16; w++) begin
            img[w*32 +: 32] = v[31:0] ^ (32'(w) * 32'h0123_4567) ^ {16'(w), 16'hA05F};
            reg_write(5'(w), img[w*32 +: 32]);
        end
        reg_write(A_CFG, {24'h0, cfg});
        reg_write(A_LEN, (32'(rxl) << 16) | 32'(txl));
        reg_read(A_LEN, rd);
        check(rd == ((32'(rxl) << 16) | 32'(txl)), "R2 len readback", rd, (32'(rxl) << 16) | 32'(txl));
        last = (cfg[5] && rxl > txl) ? rxl : txl;
        total_edges = 2 * (last + 1);
        reg_write(A_CMD, 32'h1);
        reg_read(A_CMD, rd);
        check(rd[0] == 1'b1 && spi_cs_n == 1'b0, "R3 busy after start", {rd[0], spi_cs_n}, 2'b10);
        if (poke) begin
            repeat (20) @(negedge clk);
            reg_write(A_CMD, 32'h1);
            reg_write(5'd0, 32'hDEAD_BEEF);
            reg_write(A_CFG, 32'hFF);
            reg_write(A_LEN, 32'h0001_0001);
            reg_read(A_CMD, rd);
            check(rd[0] == 1'b1, "R11 still busy after pokes", rd[0], 1);
        end
        rd = 32'h1;
        while (rd[0]) reg_read(A_CMD, rd);
        check(spi_cs_n == 1'b1 && spi_sclk == cfg[1], "R12 idle levels after done",
              {spi_cs_n, spi_sclk}, {1'b1, cfg[1]});
        check(edges == total_edges, "R4 sclk edge count", edges, total_edges);
        errs = 0;
        for (int n = 0; n <= last; n++) begin
            logic e;
            e = (n > txl) ? 1'b0 : img[bpos(n, cfg[4], cfg[2])];
            if (got[n] !== e) errs++;
        end
        check(errs == 0, "R5 R6 R7 R9 mosi stream", errs, 0);
        exp_img = img;
        if (cfg[5]) begin
            for (int n = 0; n <= rxl; n++) exp_img[bpos(n, cfg[4], cfg[3])] = sbit(n);
        end
        errs = 0;
        for (int w = 0; w < 16; w++) begin
            reg_read(5'(w), rd);
            if (rd !== exp_img[w*32 +: 32]) errs++;
        end
        check(errs == 0, "R8 R9 buffer after transfer", errs, 0);
        check(setup_ticks == (cfg[6] ? 3 : 1), "R10 setup ticks", setup_ticks, cfg[6] ? 3 : 1);
        check(hold_ticks == (cfg[7] ? 2 : 0), "R10 hold ticks", hold_ticks, cfg[7] ? 2 : 0);
        if (poke) begin
            reg_read(A_CFG, rd);
            check(rd == {24'h0, cfg}, "R11 cfg unchanged", rd, cfg);
            repeat (40) @(negedge clk);
            check(spi_cs_n == 1'b1 && edges == total_edges, "R11 no second transfer", edges, total_edges);
        end
    endtask

    initial begin
        repeat (2000 * 90) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R1 pins at reset",
              {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
        rst_n = 1'b1;
        reg_read(A_CMD, rd);
        check(rd == 32'h0, "R1 cmd at reset", rd, 0);
        reg_read(A_CFG, rd);
        check(rd == 32'h0, "R1 cfg at reset", rd, 0);
        reg_read(A_LEN, rd);
        check(rd == 32'h0, "R1 len at reset", rd, 0);
        // R2 readback while idle
        reg_write(5'd15, 32'h600D_F00D);
        reg_read(5'd15, rd);
        check(rd == 32'h600D_F00D, "R2 buffer readback", rd, 32'h600D_F00D);
        reg_write(A_CFG, 32'h0000_00A2);
        reg_read(A_CFG, rd);
        check(rd == 32'hA2, "R2 cfg readback", rd, 32'hA2);
        // R12 idle level follows polarity
        @(negedge clk);
        check(spi_sclk == 1'b1, "R12 idle sclk follows polarity", spi_sclk, 1);
        for (int i = 0; i < 9; i++) run_vec(VEC[i], 1'b0);
        run_vec({8'h22, 16'd63, 16'd63, 32'h3141_5926}, 1'b1); // R11 writes while busy
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule